// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Engine

This block moves a block of equal-sized elements from a source to a destination over a simple memory port. Software first places a three-word descriptor in memory at `desc_base`. The descriptor holds the source end pointer, the destination end pointer and a configuration word. Software then enables the channel. The transfer starts on a trigger. When `req_mask` is high the trigger is a software pulse; when it is low the trigger is the peripheral request line. The engine fetches the descriptor and then moves one element at a time, reading it and then writing it. At the end it writes the configuration word back with its mode and count fields zeroed, drops the enable and pulses the interrupt.

Pointers are kept as end addresses. The element still to be moved at remaining count `r` sits at `end - (r << inc)`, and `r` counts down from the loaded value to zero. In basic mode each trigger moves one burst of 2^rpow elements, after which the engine waits for the next trigger. In auto mode a single trigger runs the whole block, with one idle arbitration cycle after each burst. A bus error response halts the channel and sets a sticky flag.

States: `S_IDLE` (disabled), `S_WAIT` (enabled, waiting for a trigger), `S_LD_SRC` / `S_LD_DST` / `S_LD_CFG` (descriptor reads), `S_RD` (element read), `S_WR` (element write), `S_ARB` (auto-mode arbitration gap), `S_WB` (config write-back). Transitions:
- IDLE→WAIT on enable.
- WAIT→IDLE on disable.
- WAIT→LD_SRC on the first trigger; WAIT→RD on later triggers.
- LD_SRC→LD_DST→LD_CFG.
- LD_CFG→RD when the mode is runnable; LD_CFG→IDLE when it is not.
- RD→WR.
- WR→RD inside a burst.
- WR→WAIT at the end of a basic burst; WR→ARB at the end of an auto burst.
- ARB→RD.
- WR→WB on the last element; WB→IDLE.
- Any access that returns an error→IDLE.

Top module: `dmae_channel`

## Requirements
- R1: After reset the channel is disabled (`chan_en`=0), with `done_irq`=0, `bus_err`=0 and `mem_req`=0.
- R2: A pulse on `en_set` sets `chan_en`. With `req_mask`=1 only `sw_req` starts the transfer and `periph_req` is ignored. With `req_mask`=0 only `periph_req` starts it and `sw_req` is ignored.
- R3: On the first trigger the engine reads three 32-bit words: the source end pointer at `desc_base`, the destination end pointer at `desc_base+4` and the config word at `desc_base+8`. Config layout: mode [2:0], rpow [7:4], size [9:8], src inc [11:10], dst inc [13:12], count [25:16].
- R4: Size codes are 00 byte, 01 halfword and 10 word. The same size applies to both sides and is driven on `mem_size` for element accesses. Descriptor accesses use size 10.
- R5: An inc field equal to the size code steps the address. Element address = end − (remaining << inc). Inc code 11 keeps the address fixed at the end pointer.
- R6: The engine moves count+1 elements, from 1 up to 1024. Each element is read and then written before the count decrements.
- R7: In basic mode (mode 1) each trigger moves 2^rpow elements, or fewer for the final burst. The engine then waits in the enabled state for the next trigger.
- R8: In auto mode (mode 2) one trigger completes the whole block, whatever rpow is.
- R9: On completion the config word is written back with mode and count zeroed and all other bits kept. `chan_en` then falls and `done_irq` pulses for exactly one cycle.
- R10: A loaded mode of 0 or 3..7 disables the channel. No element is moved, nothing is written back and no interrupt is raised.
- R11: An access answered with `mem_err` halts the channel. It sets a sticky `bus_err`, clears `chan_en`, pulses `done_irq` and writes nothing back. `err_clr` clears `bus_err`.
- R12: `en_clr` while waiting for a trigger returns the channel to disabled without any memory access.
- R13: A request held while `mem_ready` is low keeps its address and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_base | input | AW | Byte address of the descriptor |
| en_set | input | 1 | Enable pulse (honoured when disabled) |
| en_clr | input | 1 | Disable pulse (honoured while waiting) |
| req_mask | input | 1 | 1: software trigger; 0: peripheral trigger |
| sw_req | input | 1 | Software trigger pulse |
| periph_req | input | 1 | Peripheral request level |
| err_clr | input | 1 | Clears the sticky error flag |
| chan_en | output | 1 | Channel enabled |
| done_irq | output | 1 | One-cycle completion / error interrupt |
| bus_err | output | 1 | Sticky bus-error flag |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data (low-aligned) |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with ready |
| mem_err | input | 1 | Error response, valid with ready |

## Verification
Copies are run with each of the three sizes and with stepping or fixed pointers on either side. Fixed pointers show whether the end-pointer arithmetic really holds the address still or only looks right by accident. A count of 0 and a count of 1023 test both ends of the count range. Basic mode with a small rpow, fed single triggers, separates per-burst triggering from free running, while auto mode with rpow 0 shows that re-arbitration does not need a new request. Randomised copies under a randomly stalling `mem_ready` exercise the handshake and the mode and size mixes. Error injection, a stopped mode and a disable while waiting cover the paths that must leave memory and the interrupt untouched.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT,
        S_LD_SRC,
        S_LD_DST,
        S_LD_CFG,
        S_RD,
        S_WR,
        S_ARB,
        S_WB
    } dmae_state_t;

    // config word field positions
    localparam int CFG_MODE_LSB = 0;
    localparam int CFG_MODE_W   = 3;
    localparam int CFG_RPOW_LSB = 4;
    localparam int CFG_SIZE_LSB = 8;
    localparam int CFG_SINC_LSB = 10;
    localparam int CFG_DINC_LSB = 12;
    localparam int CFG_CNT_LSB  = 16;

    localparam logic [2:0] MODE_BASIC = 3'd1;
    localparam logic [2:0] MODE_AUTO  = 3'd2;
    localparam logic [1:0] INC_FIXED  = 2'b11;
    localparam logic [1:0] SIZE_WORD  = 2'b10;

endpackage

// File: rtl/dmae_addr_gen.sv
module dmae_addr_gen #(
    parameter int AW = 32,
    parameter int CW = 10
) (
    input  logic [AW-1:0] end_addr,
    input  logic [CW-1:0] remain,
    input  logic [1:0]    inc,
    output logic [AW-1:0] addr
);
    import dmae_pkg::*;

    logic [AW-1:0] offset;

    always_comb begin
        offset = AW'(remain) << inc;
        if (inc == INC_FIXED) addr = end_addr;
        else                  addr = end_addr - offset;
    end

endmodule

// File: rtl/dmae_burst_ctr.sv
module dmae_burst_ctr #(
    parameter int CW = 10,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [PW-1:0] rpow,
    output logic          last
);
    localparam int BW = CW + 1;

    logic [BW-1:0] bcnt_q;
    logic [BW-1:0] limit;

    always_comb begin
        limit = (BW'(1) << rpow) - BW'(1);
        last  = (bcnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bcnt_q <= '0;
        else if (clear)  bcnt_q <= '0;
        else if (step)   bcnt_q <= last ? '0 : bcnt_q + BW'(1);
    end

endmodule

// File: rtl/dmae_req_sel.sv
module dmae_req_sel (
    input  logic req_mask,
    input  logic sw_req,
    input  logic periph_req,
    output logic trig
);
    always_comb trig = req_mask ? sw_req : periph_req;
endmodule

// File: rtl/dmae_channel.sv
module dmae_channel #(
    parameter int AW = 32,
    parameter int CW = 10,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] desc_base,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic          req_mask,
    input  logic          sw_req,
    input  logic          periph_req,
    input  logic          err_clr,
    output logic          chan_en,
    output logic          done_irq,
    output logic          bus_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_err
);
    import dmae_pkg::*;

    localparam logic [AW-1:0] OFS_DST = AW'(4);
    localparam logic [AW-1:0] OFS_CFG = AW'(8);

    dmae_state_t state_q, state_d;

    logic [AW-1:0] src_end_q, dst_end_q;
    logic [31:0]   cfg_q;
    logic [CW-1:0] remain_q;
    logic [31:0]   data_q;
    logic          loaded_q;
    logic          err_q;
    logic          irq_q;

    logic          accept, fault, trig, burst_last, burst_step, burst_clr;
    logic [AW-1:0] src_addr, dst_addr;
    logic [2:0]    cfg_mode;
    logic [2:0]    new_mode;
    logic [1:0]    cfg_size;
    logic [31:0]   wb_word;

    always_comb begin
        cfg_mode = cfg_q[CFG_MODE_LSB +: CFG_MODE_W];
        cfg_size = cfg_q[CFG_SIZE_LSB +: 2];
        new_mode = mem_rdata[CFG_MODE_LSB +: CFG_MODE_W];
        accept   = mem_req && mem_ready;
        fault    = accept && mem_err;
        wb_word  = cfg_q;
        wb_word[CFG_MODE_LSB +: CFG_MODE_W] = '0;
        wb_word[CFG_CNT_LSB +: CW]          = '0;
    end

    dmae_req_sel u_req_sel (
        .req_mask   (req_mask),
        .sw_req     (sw_req),
        .periph_req (periph_req),
        .trig       (trig)
    );

    dmae_addr_gen #(.AW(AW), .CW(CW)) u_src_addr (
        .end_addr (src_end_q),
        .remain   (remain_q),
        .inc      (cfg_q[CFG_SINC_LSB +: 2]),
        .addr     (src_addr)
    );

    dmae_addr_gen #(.AW(AW), .CW(CW)) u_dst_addr (
        .end_addr (dst_end_q),
        .remain   (remain_q),
        .inc      (cfg_q[CFG_DINC_LSB +: 2]),
        .addr     (dst_addr)
    );

    always_comb begin
        burst_step = (state_q == S_WR) && accept && !mem_err;
        burst_clr  = (state_q == S_IDLE) || (state_q == S_LD_CFG);
    end

    dmae_burst_ctr #(.CW(CW), .PW(PW)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (burst_clr),
        .step  (burst_step),
        .rpow  (cfg_q[CFG_RPOW_LSB +: PW]),
        .last  (burst_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (en_set) state_d = S_WAIT;
            S_WAIT: begin
                if (en_clr)    state_d = S_IDLE;
                else if (trig) state_d = loaded_q ? S_RD : S_LD_SRC;
            end
            S_LD_SRC: if (accept) state_d = fault ? S_IDLE : S_LD_DST;
            S_LD_DST: if (accept) state_d = fault ? S_IDLE : S_LD_CFG;
            S_LD_CFG: begin
                if (accept) begin
                    if (fault) state_d = S_IDLE;
                    else if (new_mode == MODE_BASIC || new_mode == MODE_AUTO)
                        state_d = S_RD;
                    else
                        state_d = S_IDLE;
                end
            end
            S_RD: if (accept) state_d = fault ? S_IDLE : S_WR;
            S_WR: begin
                if (accept) begin
                    if (fault)               state_d = S_IDLE;
                    else if (remain_q == '0) state_d = S_WB;
                    else if (burst_last)
                        state_d = (cfg_mode == MODE_AUTO) ? S_ARB : S_WAIT;
                    else                     state_d = S_RD;
                end
            end
            S_ARB: state_d = S_RD;
            S_WB:  if (accept) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_end_q <= '0;
            dst_end_q <= '0;
            cfg_q     <= '0;
            remain_q  <= '0;
            data_q    <= '0;
            loaded_q  <= 1'b0;
            err_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= fault || ((state_q == S_WB) && accept);
            if (fault)        err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;

            if (state_q == S_IDLE) loaded_q <= 1'b0;

            if (accept && !mem_err) begin
                unique case (state_q)
                    S_LD_SRC: src_end_q <= mem_rdata[AW-1:0];
                    S_LD_DST: dst_end_q <= mem_rdata[AW-1:0];
                    S_LD_CFG: begin
                        cfg_q    <= mem_rdata;
                        remain_q <= mem_rdata[CFG_CNT_LSB +: CW];
                        loaded_q <= 1'b1;
                    end
                    S_RD: data_q <= mem_rdata;
                    S_WR: if (remain_q != '0) remain_q <= remain_q - CW'(1);
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = SIZE_WORD;
        mem_wdata = '0;
        unique case (state_q)
            S_LD_SRC: begin mem_req = 1'b1; mem_addr = desc_base; end
            S_LD_DST: begin mem_req = 1'b1; mem_addr = desc_base + OFS_DST; end
            S_LD_CFG: begin mem_req = 1'b1; mem_addr = desc_base + OFS_CFG; end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
                mem_size = cfg_size;
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_addr;
                mem_size  = cfg_size;
                mem_wdata = data_q;
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_base + OFS_CFG;
                mem_wdata = wb_word;
            end
            default: ;
        endcase
        chan_en  = (state_q != S_IDLE);
        done_irq = irq_q;
        bus_err  = err_q;
    end

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R13
    AST_IRQ_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !chan_en); // R9
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> $past(mem_req && mem_ready && mem_err)); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err && !err_clr |=> bus_err); // R11
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && mem_err |=> !chan_en); // R11

endmodule

// File: tb/tb_dmae_channel.sv
module tb_dmae_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] desc_base = 32'h0;
    logic        en_set = 0, en_clr = 0, req_mask = 1, sw_req = 0, periph_req = 0, err_clr = 0;
    logic        chan_en, done_irq, bus_err, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_ready = 1'b1, mem_err;

    logic [7:0]  mem  [0:4095];
    logic [7:0]  expm [0:4095];
    logic        err_arm = 0;
    logic [31:0] err_addr = 0;
    logic        rdy_rand = 0;
    int          vecs = 0, fails = 0;
    int          wr_cnt = 0, rd_cnt = 0, irq_cnt = 0;

    always #10 clk = ~clk;

    dmae_channel dut (
        .clk(clk), .rst_n(rst_n), .desc_base(desc_base),
        .en_set(en_set), .en_clr(en_clr), .req_mask(req_mask),
        .sw_req(sw_req), .periph_req(periph_req), .err_clr(err_clr),
        .chan_en(chan_en), .done_irq(done_irq), .bus_err(bus_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    // memory model
    always_comb begin
        logic [11:0] a;
        a = mem_addr[11:0];
        mem_rdata = {mem[12'(a+3)], mem[12'(a+2)], mem[12'(a+1)], mem[a]};
        if (mem_size == 2'b00)      mem_rdata = {24'h0, mem_rdata[7:0]};
        else if (mem_size == 2'b01) mem_rdata = {16'h0, mem_rdata[15:0]};
    end
    assign mem_err = err_arm && mem_req && mem_ready && (mem_addr == err_addr);

    always @(posedge clk) begin
        if (mem_req && mem_ready && !mem_err) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata[7:0];
                if (mem_size != 2'b00) mem[12'(mem_addr[11:0]+1)] <= mem_wdata[15:8];
                if (mem_size == 2'b10) begin
                    mem[12'(mem_addr[11:0]+2)] <= mem_wdata[23:16];
                    mem[12'(mem_addr[11:0]+3)] <= mem_wdata[31:24];
                end
                if (mem_addr >= 32'h100) wr_cnt <= wr_cnt + 1;
            end else if (mem_addr >= 32'h100) rd_cnt <= rd_cnt + 1;
        end
        if (done_irq) irq_cnt <= irq_cnt + 1;
    end

    always @(negedge clk) mem_ready <= rdy_rand ? (($urandom % 4) != 0) : 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic wr32(input int a, input logic [31:0] v);
        mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = v[23:16]; mem[a+3] = v[31:24];
    endtask

    function automatic logic [31:0] mk_cfg(input logic [2:0] mode, input logic [3:0] rpow,
            input logic [1:0] sz, input logic [1:0] si, input logic [1:0] di, input int cnt);
        return {6'h0, 10'(cnt), 2'b00, di, si, sz, rpow, 1'b0, mode};
    endfunction

    // load descriptor and data, build expected image
    task automatic prep(input int base, input logic [2:0] mode, input logic [3:0] rpow,
                        input logic [1:0] sz, input bit sfix, input bit dfix, input int cnt,
                        output logic [31:0] cfg);
        int e;
        int s0;
        int d0;
        e = 1 << sz;
        s0 = 32'h100;
        d0 = 32'h800;
        for (int i = 32'h100; i < 32'h800; i++) mem[i] = 8'($urandom);
        for (int i = 32'h800; i < 4096; i++) mem[i] = 8'h00;
        cfg = mk_cfg(mode, rpow, sz, sfix ? 2'b11 : sz, dfix ? 2'b11 : sz, cnt);
        wr32(base, sfix ? s0 : s0 + cnt * e);
        wr32(base + 4, dfix ? d0 : d0 + cnt * e);
        wr32(base + 8, cfg);
        desc_base = base;
        for (int i = 0; i < 4096; i++) expm[i] = mem[i];
        if (mode == 3'd1 || mode == 3'd2)
            for (int i = 0; i <= cnt; i++)
                for (int b = 0; b < e; b++)
                    expm[(dfix ? d0 : d0 + i * e) + b] = mem[(sfix ? s0 : s0 + i * e) + b];
    endtask

    task automatic wait_idle();
        int g;
        g = 0;
        while (chan_en && g < 20000) begin @(negedge clk); g++; end
    endtask

    task automatic enable();
        @(negedge clk); en_set = 1; @(negedge clk); en_set = 0;
    endtask

    task automatic cmp_mem(input string req, input string what);
        int bad;
        int first;
        bad = 0;
        first = 0;
        for (int i = 32'h100; i < 4096; i++)
            if (mem[i] !== expm[i]) begin if (bad == 0) first = i; bad++; end
        chk(bad == 0, req, what, mem[first], expm[first]);
    endtask

    // full run, then checks
    task automatic run_case(input string tag, input int base, input logic [2:0] mode,
                            input logic [3:0] rpow, input logic [1:0] sz,
                            input bit sfix, input bit dfix, input int cnt);
        logic [31:0] cfg;
        int w0;
        int i0;
        prep(base, mode, rpow, sz, sfix, dfix, cnt, cfg);
        w0 = wr_cnt; i0 = irq_cnt;
        enable();
        if (mode == 3'd1) begin req_mask = 0; periph_req = 1; end
        else begin req_mask = 1; sw_req = 1; @(negedge clk); sw_req = 0; end
        wait_idle();
        periph_req = 0;
        @(negedge clk); @(negedge clk);
        $display("case %s", tag);
        chk(!chan_en, "R9", {tag, " enable cleared"}, chan_en, 0);
        chk(irq_cnt - i0 == 1, "R9", {tag, " one irq"}, irq_cnt - i0, 1);
        chk(wr_cnt - w0 == cnt + 1, "R6", {tag, " element writes"}, wr_cnt - w0, cnt + 1);
        cmp_mem("R5", {tag, " data image (R3 R4 R13)"});
        chk(rd32(base + 8) == (cfg & 32'hFC00_FFF8), "R9", {tag, " config writeback"},
            rd32(base + 8), cfg & 32'hFC00_FFF8);
        chk(!bus_err, "R11", {tag, " no error"}, bus_err, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        logic [31:0] cfg;
        int w0;
        int r0;
        int i0;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!chan_en && !done_irq && !bus_err && !mem_req, "R1", "reset state",
            {chan_en, done_irq, bus_err, mem_req}, 0);
        rst_n = 1;
        @(negedge clk);

        // directed copies
        run_case("word auto", 0, 3'd2, 4'd1, 2'b10, 0, 0, 5);          // R4 R8
        run_case("half auto", 0, 3'd2, 4'd2, 2'b01, 0, 0, 9);          // R4
        run_case("byte basic", 32'h40, 3'd1, 4'd0, 2'b00, 0, 0, 12);   // R3 R4
        run_case("fixed src max", 0, 3'd2, 4'd15, 2'b00, 1, 0, 1023);  // R6 R5
        run_case("fixed dst", 0, 3'd2, 4'd0, 2'b10, 0, 1, 3);          // R5 R8
        run_case("single", 0, 3'd1, 4'd3, 2'b01, 0, 0, 0);             // R6

        // R7 basic-mode burst stepping, R2 sw_req ignored with req_mask=0
        prep(0, 3'd1, 4'd1, 2'b10, 0, 0, 7, cfg);
        w0 = wr_cnt;
        req_mask = 0;
        enable();
        periph_req = 1; @(negedge clk); periph_req = 0;
        repeat (40) @(negedge clk);
        chk(wr_cnt - w0 == 2, "R7", "one burst per trigger", wr_cnt - w0, 2);
        chk(chan_en, "R7", "still enabled between bursts", chan_en, 1);
        sw_req = 1; @(negedge clk); sw_req = 0;
        repeat (30) @(negedge clk);
        chk(wr_cnt - w0 == 2, "R2", "sw_req ignored when unmasked", wr_cnt - w0, 2);
        periph_req = 1; @(negedge clk); periph_req = 0;
        repeat (40) @(negedge clk);
        chk(wr_cnt - w0 == 4, "R7", "second burst", wr_cnt - w0, 4);
        periph_req = 1;
        wait_idle();
        periph_req = 0;
        @(negedge clk);
        cmp_mem("R7", "burst copy image");

        // R2 periph_req ignored when masked
        prep(0, 3'd2, 4'd0, 2'b10, 0, 0, 2, cfg);
        r0 = rd_cnt;
        req_mask = 1;
        enable();
        periph_req = 1; repeat (20) @(negedge clk); periph_req = 0;
        chk(rd_cnt == r0 && chan_en, "R2", "periph_req ignored when masked", rd_cnt - r0, 0);
        sw_req = 1; @(negedge clk); sw_req = 0;
        wait_idle(); @(negedge clk);
        cmp_mem("R2", "sw_req started copy");

        // R10 stopped mode
        prep(0, 3'd0, 4'd0, 2'b10, 0, 0, 4, cfg);
        w0 = wr_cnt; i0 = irq_cnt;
        enable();
        sw_req = 1; @(negedge clk); sw_req = 0;
        repeat (20) @(negedge clk);
        chk(!chan_en, "R10", "stopped mode disables", chan_en, 0);
        chk(wr_cnt == w0 && irq_cnt == i0, "R10", "no traffic or irq", wr_cnt - w0, 0);
        chk(rd32(8) == cfg, "R10", "config untouched", rd32(8), cfg);

        // R12 disable while waiting
        prep(0, 3'd2, 4'd0, 2'b10, 0, 0, 4, cfg);
        r0 = rd_cnt;
        enable();
        en_clr = 1; @(negedge clk); en_clr = 0;
        chk(!chan_en, "R12", "disable while waiting", chan_en, 0);
        sw_req = 1; @(negedge clk); sw_req = 0;
        repeat (10) @(negedge clk);
        chk(rd_cnt == r0 && !mem_req, "R12", "no access after disable", rd_cnt - r0, 0);

        // R11 bus error
        rdy_rand = 1;
        prep(0, 3'd2, 4'd0, 2'b10, 0, 0, 6, cfg);
        i0 = irq_cnt;
        err_addr = 32'h800; err_arm = 1;
        enable();
        sw_req = 1; @(negedge clk); sw_req = 0;
        wait_idle(); @(negedge clk); @(negedge clk);
        err_arm = 0;
        chk(bus_err, "R11", "error flag set", bus_err, 1);
        chk(!chan_en && irq_cnt - i0 == 1, "R11", "halt with irq", irq_cnt - i0, 1);
        chk(rd32(8) == cfg, "R11", "no writeback on error", rd32(8), cfg);
        repeat (3) @(negedge clk);
        chk(bus_err, "R11", "error flag sticky", bus_err, 1);
        err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
        chk(!bus_err, "R11", "err_clr clears flag", bus_err, 0);

        // random mix under stalling ready (R13)
        for (int k = 0; k < 20; k++) begin
            logic [1:0] sz;
            sz = 2'($urandom % 3);
            run_case($sformatf("rand%0d", k), 4 * ($urandom % 16),
                     ($urandom % 2) ? 3'd1 : 3'd2, 4'($urandom % 5), sz,
                     1'($urandom % 4 == 0), 1'($urandom % 4 == 0), $urandom % 48);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule